// File: doc/BRIEF.md
# Synchronous Late-Write SRAM with Burst Sequencing

This block is a synthesizable model of a synchronous static RAM that needs no bus turnaround. Address, control and byte enables are registered on the rising clock edge. Write data trails its address by the same number of cycles as read data does, so a stream of reads and writes can alternate on every clock with no idle cycles between them. A static mode input picks pipelined timing (read data registered one more time, write data two cycles after the address) or flow-through timing (read data valid in the cycle after the address edge, write data one cycle after the address).

A second static input picks the burst order. A burst-continue input steps the low two address bits through four beats: linear order adds the beat count modulo 4, and interleaved order XORs the start offset with the beat count. Three chip selects must all be active to start a cycle. An output enable and a sleep input act on the read-data drive without waiting for a clock. A read that hits a write still waiting for its data is served from the write data bus, merged byte by byte, and not from the stale stored word. Storage is a small bank of registers with one bank per 9-bit byte lane.

Top module: `lw_sram`

## Requirements
- R1: A new cycle starts at a rising edge only when `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0, `burst_next`=0 and `sleep`=0. Any other combination with `burst_next`=0 is a deselect: it writes nothing, drives no read data and ends any burst.
- R2: In pipelined mode (`flow_mode`=0), a read whose address is sampled at edge k drives `rdata_drv`=1 with the stored word on `rdata` for one cycle, from edge k+1 to edge k+2.
- R3: In flow-through mode (`flow_mode`=1), a read sampled at edge k drives `rdata_drv`=1 and the stored word from edge k to edge k+1.
- R4: Write data on `wdata` is sampled at edge k+2 in pipelined mode and at edge k+1 in flow-through mode, for a write whose address is sampled at edge k (`wr_n`=0).
- R5: `lane_wr_n[i]`=0, sampled with the write address, updates bits [9i+8:9i] of the word. A lane whose enable is 1 keeps its old value.
- R6: A read issued in any cycle returns every earlier write, including a pipelined write whose data is still due, merged per lane.
- R7: With `burst_ilv`=0, each cycle with `burst_next`=1 during an active burst repeats the burst's operation at offset (start + n) mod 4 in the low two address bits, where n counts beats 1, 2, 3 and the upper bits stay fixed.
- R8: With `burst_ilv`=1, the continued beat uses offset start XOR n.
- R9: `oe_n`=1 forces `rdata_drv` to 0 at once, with no clock edge needed.
- R10: While `sleep`=1, `rdata_drv` is 0 at once, no cycle is started and no write reaches the storage.
- R11: After synchronous reset (`rst_n`=0 at an edge) the pipeline is empty and `rdata_drv` is 0.
- R12: Reads and writes may alternate on consecutive edges in both modes with no deselect cycles, and each read still meets R2/R3 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flow_mode | input | 1 | Static: 1 flow-through, 0 pipelined |
| burst_ilv | input | 1 | Static: 1 interleaved burst order, 0 linear |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_next | input | 1 | 1 continues the current burst, 0 loads a new address |
| wr_n | input | 1 | 0 write, 1 read, sampled on a new cycle |
| lane_wr_n | input | NBYTES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | NBYTES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down |
| rdata | output | NBYTES*BYTE_W | Read data, zero when not driven |
| rdata_drv | output | 1 | Pad drive enable for `rdata` |

## Verification
The assertions take `flow_mode` and `burst_ilv` as static between resets and take write data as valid in the cycle the selected mode sets for it. The stimulus changes the mode only across a reset and changes burst order only between bursts after deselect cycles. It raises `sleep` only when no write is waiting for its data, except for a short pulse between edges that tests the asynchronous output gating. Every write's data is scheduled by the bench onto the exact edge that R4 names for the current mode.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the burst-offset rule for the late-write SRAM.
package lw_sram_pkg;

    localparam int BEAT_W = 2;

    // Offset of a burst beat: XOR with the beat count for interleaved order,
    // modulo-4 add for linear order.
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              ilv
    );
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/lw_burst_seq.sv
`timescale 1ns/1ps
// Module: lw_burst_seq
// Decides per edge whether a cycle is issued and which address and direction
// it uses. A new cycle loads the address; a continue cycle steps the low two
// bits using the package offset rule. Assumes ADDR_W >= 3 and a static ilv_i.
module lw_burst_seq
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sleep_i,
    input  logic              sel_i,
    input  logic              adv_i,
    input  logic              wr_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ilv_i,
    output logic              iss_o,
    output logic              iss_wr_o,
    output logic [ADDR_W-1:0] iss_addr_o
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              act_q;
    logic              wr_q;
    logic [HI_W-1:0]   base_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] last_off_q;

    logic              start_new;
    logic              cont;
    logic [BEAT_W-1:0] cnt_nx;
    logic [BEAT_W-1:0] off_nx;

    // Classify the current edge and form the issued address.
    always_comb begin
        start_new  = !sleep_i && !adv_i && sel_i;
        cont       = !sleep_i && adv_i && act_q;
        cnt_nx     = cnt_q + 1'b1;
        off_nx     = beat_offset(start_q, cnt_nx, ilv_i);
        iss_o      = start_new || cont;
        iss_wr_o   = start_new ? !wr_n_i : wr_q;
        iss_addr_o = start_new ? addr_i : {base_q, off_nx};
    end

    // Hold the burst state: base, start offset, beat count and direction.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            act_q      <= 1'b0;
            wr_q       <= 1'b0;
            base_q     <= '0;
            start_q    <= '0;
            cnt_q      <= '0;
            last_off_q <= '0;
        end else if (start_new) begin
            act_q      <= 1'b1;
            wr_q       <= !wr_n_i;
            base_q     <= addr_i[ADDR_W-1:BEAT_W];
            start_q    <= addr_i[BEAT_W-1:0];
            cnt_q      <= '0;
            last_off_q <= addr_i[BEAT_W-1:0];
        end else if (cont) begin
            cnt_q      <= cnt_nx;
            last_off_q <= off_nx;
        end else begin
            act_q      <= 1'b0;
        end
    end

    p_new_loads_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_new |=> act_q && cnt_q == '0 && last_off_q == $past(addr_i[BEAT_W-1:0]));

    p_lin_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cont && !ilv_i) |=> last_off_q == BEAT_W'($past(last_off_q) + 1'b1));

    p_ilv_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cont && ilv_i) |=> (last_off_q ^ start_q) == cnt_q);

    p_sleep_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_i |=> !act_q);

endmodule

// File: rtl/lw_ctrl_pipe.sv
`timescale 1ns/1ps
// Module: lw_ctrl_pipe
// Carries issued cycles through one stage (flow-through) or two stages
// (pipelined) so the array write lines up with the late write data, and flags
// lanes of a waiting write that a newer read must take from the data bus.
// Assumes flow_i changes only across a reset.
module lw_ctrl_pipe #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flow_i,
    input  logic              sleep_i,
    input  logic              iss_i,
    input  logic              iss_wr_i,
    input  logic [ADDR_W-1:0] iss_addr_i,
    input  logic [NBYTES-1:0] lane_wr_n_i,
    output logic              s1_rd_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] wa_o,
    output logic [NBYTES-1:0] wbe_o,
    output logic [NBYTES-1:0] fwd_be_o
);

    logic              s1_v_q;
    logic              s1_wr_q;
    logic [ADDR_W-1:0] s1_addr_q;
    logic [NBYTES-1:0] s1_be_q;
    logic              s2_wr_q;
    logic [ADDR_W-1:0] s2_addr_q;
    logic [NBYTES-1:0] s2_be_q;

    // Advance the issued cycle through the address stages.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s1_v_q    <= 1'b0;
            s1_wr_q   <= 1'b0;
            s1_addr_q <= '0;
            s1_be_q   <= '0;
            s2_wr_q   <= 1'b0;
            s2_addr_q <= '0;
            s2_be_q   <= '0;
        end else begin
            s1_v_q    <= iss_i;
            s1_wr_q   <= iss_i && iss_wr_i;
            s1_addr_q <= iss_addr_i;
            s1_be_q   <= ~lane_wr_n_i;
            s2_wr_q   <= !flow_i && s1_wr_q;
            s2_addr_q <= s1_addr_q;
            s2_be_q   <= s1_be_q;
        end
    end

    // Pick the stage whose write commits at the next edge; find forwarded lanes.
    always_comb begin
        s1_rd_o   = s1_v_q && !s1_wr_q;
        rd_addr_o = s1_addr_q;
        we_o      = !sleep_i && (flow_i ? s1_wr_q : s2_wr_q);
        wa_o      = flow_i ? s1_addr_q : s2_addr_q;
        wbe_o     = flow_i ? s1_be_q : s2_be_q;
        fwd_be_o  = (!flow_i && !sleep_i && s2_wr_q && s1_rd_o && s2_addr_q == s1_addr_q)
                    ? s2_be_q : '0;
    end

    p_flow_one_stage_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flow_i && $past(flow_i)) |-> !s2_wr_q);

    p_wr_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_o |-> (flow_i ? $past(iss_i && iss_wr_i) : $past(iss_i && iss_wr_i, 2)));

endmodule

// File: rtl/lw_array.sv
`timescale 1ns/1ps
// Module: lw_array
// Register storage split into one bank per byte lane. Write is synchronous
// with per-lane enables; read is combinational. Contents have no reset.
module lw_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk_i,
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        wa_i,
    input  logic [NBYTES-1:0]        wbe_i,
    input  logic [NBYTES*BYTE_W-1:0] wd_i,
    input  logic [ADDR_W-1:0]        ra_i,
    output logic [NBYTES*BYTE_W-1:0] rd_o
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] bank [DEPTH];

        // Store this lane when the write is enabled for it.
        always_ff @(posedge clk_i) begin
            if (we_i && wbe_i[g]) begin
                bank[wa_i] <= wd_i[g*BYTE_W +: BYTE_W];
            end
        end

        assign rd_o[g*BYTE_W +: BYTE_W] = bank[ra_i];
    end

endmodule

// File: rtl/lw_read_path.sv
`timescale 1ns/1ps
// Module: lw_read_path
// Forms read data: in pipelined mode it merges forwarded write lanes into the
// array word and registers the result; in flow-through mode it passes the
// array word straight on. Output enable and sleep gate the drive directly.
module lw_read_path #(
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     flow_i,
    input  logic                     s1_rd_i,
    input  logic [NBYTES*BYTE_W-1:0] arr_q_i,
    input  logic [NBYTES*BYTE_W-1:0] wd_i,
    input  logic [NBYTES-1:0]        fwd_be_i,
    input  logic                     oe_ni,
    input  logic                     sleep_i,
    output logic [NBYTES*BYTE_W-1:0] q_o,
    output logic                     q_en_o
);

    localparam int DW = NBYTES * BYTE_W;

    logic [DW-1:0] merged;
    logic [DW-1:0] q_reg_q;
    logic          qv_q;
    logic [DW-1:0] data_sel;
    logic          vld;

    for (genvar g = 0; g < NBYTES; g++) begin : g_merge
        assign merged[g*BYTE_W +: BYTE_W] = fwd_be_i[g] ? wd_i[g*BYTE_W +: BYTE_W]
                                                        : arr_q_i[g*BYTE_W +: BYTE_W];
    end

    // Output register for pipelined reads.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            qv_q    <= 1'b0;
            q_reg_q <= '0;
        end else begin
            qv_q    <= s1_rd_i && !flow_i;
            q_reg_q <= merged;
        end
    end

    // Select the timing variant and apply the asynchronous gates.
    always_comb begin
        data_sel = flow_i ? arr_q_i : q_reg_q;
        vld      = flow_i ? s1_rd_i : qv_q;
        q_en_o   = vld && !oe_ni && !sleep_i;
        q_o      = q_en_o ? data_sel : '0;
    end

    p_pipe_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!flow_i && s1_rd_i) |=> qv_q);

    p_flow_no_reg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flow_i && $past(flow_i)) |-> !qv_q);

    p_fwd_only_pipe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|fwd_be_i) |-> (!flow_i && s1_rd_i));

endmodule

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
// Module: lw_sram (top)
// Synchronous late-write SRAM: burst sequencer, address pipeline, lane-banked
// storage and read path. Assumes flow_mode changes only across a reset and
// that write data arrives on the edge the selected mode sets for it.
module lw_sram #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flow_mode,
    input  logic                     burst_ilv,
    input  logic                     sel_a_n,
    input  logic                     sel_b,
    input  logic                     sel_c_n,
    input  logic                     burst_next,
    input  logic                     wr_n,
    input  logic [NBYTES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic                     oe_n,
    input  logic                     sleep,
    output logic [NBYTES*BYTE_W-1:0] rdata,
    output logic                     rdata_drv
);

    localparam int DW = NBYTES * BYTE_W;

    logic              sel_all;
    logic              iss;
    logic              iss_wr;
    logic [ADDR_W-1:0] iss_addr;
    logic              s1_rd;
    logic [ADDR_W-1:0] rd_addr;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_wa;
    logic [NBYTES-1:0] arr_wbe;
    logic [NBYTES-1:0] fwd_be;
    logic [DW-1:0]     arr_q;

    assign sel_all = !sel_a_n && sel_b && !sel_c_n;

    lw_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sleep_i    (sleep),
        .sel_i      (sel_all),
        .adv_i      (burst_next),
        .wr_n_i     (wr_n),
        .addr_i     (addr),
        .ilv_i      (burst_ilv),
        .iss_o      (iss),
        .iss_wr_o   (iss_wr),
        .iss_addr_o (iss_addr)
    );

    lw_ctrl_pipe #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_pipe (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .flow_i      (flow_mode),
        .sleep_i     (sleep),
        .iss_i       (iss),
        .iss_wr_i    (iss_wr),
        .iss_addr_i  (iss_addr),
        .lane_wr_n_i (lane_wr_n),
        .s1_rd_o     (s1_rd),
        .rd_addr_o   (rd_addr),
        .we_o        (arr_we),
        .wa_o        (arr_wa),
        .wbe_o       (arr_wbe),
        .fwd_be_o    (fwd_be)
    );

    lw_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_arr (
        .clk_i (clk),
        .we_i  (arr_we),
        .wa_i  (arr_wa),
        .wbe_i (arr_wbe),
        .wd_i  (wdata),
        .ra_i  (rd_addr),
        .rd_o  (arr_q)
    );

    lw_read_path #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_rd (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .flow_i   (flow_mode),
        .s1_rd_i  (s1_rd),
        .arr_q_i  (arr_q),
        .wd_i     (wdata),
        .fwd_be_i (fwd_be),
        .oe_ni    (oe_n),
        .sleep_i  (sleep),
        .q_o      (rdata),
        .q_en_o   (rdata_drv)
    );

    p_oe_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_drv);

    p_sleep_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!arr_we && !rdata_drv));

    p_issue_needs_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (iss && !burst_next) |-> sel_all);

endmodule

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;

    localparam int AW    = 6;
    localparam int NB    = 2;
    localparam int BW    = 9;
    localparam int DW    = NB * BW;
    localparam int DEPTH = 1 << AW;
    localparam int MAXC  = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flow_mode = 1'b0;
    logic          burst_ilv = 1'b0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          burst_next = 1'b0;
    logic          wr_n = 1'b1;
    logic [NB-1:0] lane_wr_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_drv;

    lw_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .burst_ilv(burst_ilv),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .burst_next(burst_next),
        .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr), .wdata(wdata),
        .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .rdata_drv(rdata_drv)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int c = 0;
    int probe = 0;
    string cur_tag = "R2";

    logic [DW-1:0] model [DEPTH];
    logic          exp_v [MAXC];
    logic [DW-1:0] exp_d [MAXC];
    string         exp_t [MAXC];
    logic [DW-1:0] wd_s  [MAXC];

    bit            b_act = 0;
    bit            b_wr = 0;
    logic [AW-3:0] b_base = '0;
    logic [1:0]    b_start = '0;
    logic [1:0]    b_cnt = '0;

    function automatic logic [DW-1:0] pat(int a, int salt);
        return DW'(a * 1031 + salt * 7919 + 'h15a5a);
    endfunction

    function automatic logic [1:0] offs(logic [1:0] s, logic [1:0] n);
        return burst_ilv ? (s ^ n) : 2'(s + n);
    endfunction

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic clear_sched();
        for (int i = 0; i < MAXC; i++) begin
            exp_v[i] = 1'b0;
            exp_d[i] = '0;
            exp_t[i] = "R1";
            wd_s[i]  = '0;
        end
    endtask

    // Compare outputs that follow edge c-1; optionally probe async gates.
    task automatic observe();
        if (c > 0) begin
            int k;
            k = c - 1;
            if (exp_v[k]) begin
                chk(rdata_drv === 1'b1 && rdata === exp_d[k], exp_t[k], rdata, exp_d[k]);
                if (probe == 1) begin
                    oe_n = 1'b1;
                    #1;
                    chk(rdata_drv === 1'b0, "R9 oe_n high", DW'(rdata_drv), '0);
                    oe_n = 1'b0;
                    #1;
                    chk(rdata_drv === 1'b1 && rdata === exp_d[k], "R9 oe_n low", rdata, exp_d[k]);
                    probe = 0;
                end else if (probe == 2) begin
                    sleep = 1'b1;
                    #1;
                    chk(rdata_drv === 1'b0, "R10 sleep async", DW'(rdata_drv), '0);
                    sleep = 1'b0;
                    #1;
                    probe = 0;
                end
            end else begin
                chk(rdata_drv === 1'b0, "R1 no drive", DW'(rdata_drv), '0);
            end
        end
    endtask

    // Drive the inputs for edge c and update the reference model.
    task automatic drive(bit s1n, bit s2, bit s3n, bit av, bit wn,
                         logic [AW-1:0] a, logic [NB-1:0] bwn, logic [DW-1:0] wd, bit slp);
        bit            nw;
        bit            ct;
        bit            ewr;
        logic [AW-1:0] ea;
        @(negedge clk);
        observe();
        sel_a_n = s1n; sel_b = s2; sel_c_n = s3n; burst_next = av;
        wr_n = wn; addr = a; lane_wr_n = bwn; sleep = slp;
        wdata = wd_s[c];
        nw  = !slp && !av && !s1n && s2 && !s3n;
        ct  = !slp && av && b_act;
        ea  = a;
        ewr = !wn;
        if (nw) begin
            b_act = 1; b_wr = !wn; b_base = a[AW-1:2]; b_start = a[1:0]; b_cnt = '0;
        end else if (ct) begin
            b_cnt = b_cnt + 2'd1;
            ea    = {b_base, offs(b_start, b_cnt)};
            ewr   = b_wr;
        end else begin
            b_act = 0;
        end
        if (nw || ct) begin
            if (ewr) begin
                for (int g = 0; g < NB; g++)
                    if (!bwn[g]) model[ea][g*BW +: BW] = wd[g*BW +: BW];
                wd_s[c + (flow_mode ? 1 : 2)] = wd;
            end else begin
                exp_v[c + (flow_mode ? 0 : 1)] = 1'b1;
                exp_d[c + (flow_mode ? 0 : 1)] = model[ea];
                exp_t[c + (flow_mode ? 0 : 1)] = cur_tag;
            end
        end
        c++;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [NB-1:0] bwn, logic [DW-1:0] wd);
        drive(0, 1, 0, 0, 0, a, bwn, wd, 0);
    endtask
    task automatic rd(logic [AW-1:0] a);
        drive(0, 1, 0, 0, 1, a, '1, '0, 0);
    endtask
    task automatic adv(logic [NB-1:0] bwn, logic [DW-1:0] wd);
        drive(1, 0, 1, 1, 1, '0, bwn, wd, 0);
    endtask
    task automatic nop(int n);
        for (int i = 0; i < n; i++) drive(1, 0, 1, 0, 1, '0, '1, '0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sel_a_n = 1; sel_b = 0; sel_c_n = 1; burst_next = 0; sleep = 0; oe_n = 0;
        @(negedge clk);
        @(negedge clk);
        chk(rdata_drv === 1'b0, "R11 reset idle", DW'(rdata_drv), '0);
        rst_n = 1'b1;
        c = 0; b_act = 0;
        clear_sched();
    endtask

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            flow_mode = m[0];
            burst_ilv = 1'b0;
            do_reset();
            // R4: fill every word, then read back-to-back (R2 or R3)
            for (int a = 0; a < DEPTH; a++) wr(AW'(a), 2'b00, pat(a, m));
            cur_tag = m ? "R3 R4 flow read" : "R2 R4 pipe read";
            for (int a = 0; a < DEPTH; a++) rd(AW'(a));
            // R5, R6, R12: write then read same word, all lane patterns
            cur_tag = "R5 R6 R12 lanes and forward";
            for (int a = 0; a < DEPTH; a++) begin
                wr(AW'(a), 2'(a % 4), pat(a, m + 10));
                rd(AW'(a));
            end
            // R12: read, write neighbour, alternating each edge
            cur_tag = "R12 alternate";
            for (int a = 0; a < DEPTH; a++) begin
                rd(AW'(a));
                wr(AW'(a ^ 1), 2'b00, pat(a, m + 20));
            end
            nop(3);
            // R7 / R8: write burst from each start, read burst from another
            for (int o = 0; o < 2; o++) begin
                burst_ilv = o[0];
                cur_tag = o ? "R8 interleaved burst" : "R7 linear burst";
                for (int s = 0; s < 4; s++) begin
                    wr({4'(8 + s), 2'(s)}, 2'b00, pat(s, 40 + o));
                    for (int b = 1; b < 4; b++) adv(2'b00, pat(s * 4 + b, 50 + o));
                    rd({4'(8 + s), 2'(s + 1)});
                    for (int b = 1; b < 4; b++) adv('1, '0);
                end
                nop(3);
            end
            burst_ilv = 1'b0;
            // R1: each single inactive select blocks a write; continue without burst does nothing
            cur_tag = "R1 select";
            drive(1, 1, 0, 0, 0, 6'd3, 2'b00, pat(3, 99), 0);
            drive(0, 0, 0, 0, 0, 6'd3, 2'b00, pat(3, 98), 0);
            drive(0, 1, 1, 0, 0, 6'd3, 2'b00, pat(3, 97), 0);
            adv(2'b00, pat(3, 96));
            nop(3);
            rd(6'd3);
            nop(3);
            // R10: cycles presented during sleep take no effect
            cur_tag = "R10 sleep";
            drive(0, 1, 0, 0, 0, 6'd4, 2'b00, pat(4, 77), 1);
            drive(0, 1, 0, 0, 1, 6'd4, '1, '0, 1);
            drive(1, 0, 1, 0, 1, '0, '1, '0, 1);
            nop(2);
            rd(6'd4);
            probe = 2;
            rd(6'd6);
            nop(3);
            // R9: output enable probe on a live read
            cur_tag = "R9 read";
            probe = 1;
            rd(6'd7);
            nop(4);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule